// File: doc/BRIEF.md
# Masked Packed Dword-to-Byte Narrower

This unit narrows up to sixteen 32-bit lanes of a 512-bit source vector into a packed run of bytes. Each lane is converted by one of three rules, chosen by an opcode byte:
- keep the low byte (truncation),
- clamp as a signed integer into the signed byte range,
- clamp as an unsigned integer into 0..255.

The vector-length select decides how many lanes take part: 4, 8 or 16. The converted bytes are packed from the least-significant byte of the 128-bit result upward.

A per-lane write mask, together with a mask-enable flag, decides which lanes receive their converted byte. For a register destination, a lane that is masked off either keeps the old destination byte (merging) or becomes zero (zeroing). Every byte above the packed region is cleared, and all sixteen byte enables are raised because the whole register is written.

For a memory destination, only merging is legal. The unit raises a byte enable for each written lane and for no other byte, so the store leaves every other byte untouched. Four kinds of encoding are rejected:
- a 4-bit auxiliary specifier other than all ones,
- an unknown opcode,
- the reserved length code,
- zeroing requested together with a memory destination.

Each of these raises an undefined-opcode fault and suppresses every write. The result is registered once and updates on the clock edge that samples `in_valid` high.

Top module: `dword_byte_narrower`

## Requirements
- R1: With opcode 0x31, every active lane j gives the low byte of source bits [32j+31:32j] at result bits [8j+7:8j]. The length code selects the active lanes: 0 gives lanes 0-3, 1 gives lanes 0-7 and 2 gives lanes 0-15.
- R2: With opcode 0x11, a lane value above 255 gives 0xFF, and any other value passes its low byte.
- R3: With opcode 0x21, the lane is read as a signed 32-bit value. Values above 127 give 0x7F, values below -128 give 0x80, and values in range keep their low byte.
- R4: For a register destination with masking on and zeroing off, an active lane whose mask bit is 0 keeps the byte of `old_dst` at its position.
- R5: For a register destination with masking and zeroing both on, an active lane whose mask bit is 0 gives 0x00.
- R6: With `mask_en` low, every active lane takes its converted byte, whatever the values of `mask` and `zero_en`.
- R7: For a register destination, result bytes at and above the active lane count are 0x00, and `byte_we` is 0xFFFF.
- R8: For a memory destination, `byte_we[j]` is 1 exactly when lane j is active and (`mask[j]` is 1 or `mask_en` is 0). Result bytes whose enable is 0 carry the `old_dst` byte.
- R9: If `aux_spec` is not 4'b1111, `ud_fault` is 1, `result` is all zero and `byte_we` is all zero.
- R10: If `zero_en` and `dst_mem` are both 1, `ud_fault` is 1, `result` is all zero and `byte_we` is all zero.
- R11: An opcode other than 0x31, 0x21 or 0x11, or the length code 3, sets `ud_fault` and zeroes `result` and `byte_we`.
- R12: The outputs are zero after reset. `out_valid` is `in_valid` delayed by one cycle. `result`, `byte_we` and `ud_fault` change only on an edge where `in_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture enable for the operands |
| opcode | input | 8 | Conversion select: 0x31 truncation, 0x21 signed clamp, 0x11 unsigned clamp |
| vl_sel | input | 2 | Vector length: 0 = 4 lanes, 1 = 8 lanes, 2 = 16 lanes, 3 reserved |
| aux_spec | input | 4 | Auxiliary specifier; must be 4'b1111 |
| mask_en | input | 1 | Apply the per-lane mask |
| mask | input | 16 | Per-lane write mask |
| zero_en | input | 1 | Zero masked-off lanes instead of merging |
| dst_mem | input | 1 | Destination is memory (1) or a register (0) |
| src | input | 512 | Source lanes, lane j at bits [32j+31:32j] |
| old_dst | input | 128 | Previous destination contents |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 128 | Packed byte result |
| byte_we | output | 16 | Per-byte write enable |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The hardest situations to reach are those where several qualifiers interact on one operation. Examples are a memory store at the shortest length with a sparse mask, where enables must stop at lane 3 while bytes above carry old data, and a masked-off lane that would have saturated. The stimulus table pairs each mode with masks such as 0xA5C3 and 0xBEEF. Each lane's source value is taken from a rotating set of corner values (0x7F, 0x80, 0xFF, 0x100, 0x80000000, 0xFFFFFF7F and others), so every saturation edge falls into both written and skipped lanes. Faulting encodings reuse live masks and data, so any write that leaks past the fault shows up.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

  typedef enum logic [1:0] {
    NM_TRUNC = 2'd0,
    NM_SSAT  = 2'd1,
    NM_USAT  = 2'd2
  } narrow_mode_e;

  localparam logic [7:0] OPC_TRUNC = 8'h31;
  localparam logic [7:0] OPC_SSAT  = 8'h21;
  localparam logic [7:0] OPC_USAT  = 8'h11;

  localparam logic [3:0] AUX_LEGAL = 4'b1111;

endpackage

// File: rtl/narrow_decode.sv
module narrow_decode
  import narrow_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [7:0]       opcode,
  input  logic [1:0]       vl_sel,
  input  logic [3:0]       aux_spec,
  input  logic             zero_en,
  input  logic             dst_mem,
  output narrow_mode_e     mode,
  output logic [LANES-1:0] lane_on,
  output logic             fault
);

  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0] lane_count;
  logic             bad_opc;
  logic             bad_len;

  always_comb begin
    bad_opc = 1'b0;
    case (opcode)
      OPC_TRUNC: mode = NM_TRUNC;
      OPC_SSAT:  mode = NM_SSAT;
      OPC_USAT:  mode = NM_USAT;
      default: begin
        mode    = NM_TRUNC;
        bad_opc = 1'b1;
      end
    endcase
  end

  always_comb begin
    bad_len = 1'b0;
    case (vl_sel)
      2'd0:    lane_count = CNT_W'(LANES / 4);
      2'd1:    lane_count = CNT_W'(LANES / 2);
      2'd2:    lane_count = CNT_W'(LANES);
      default: begin
        lane_count = '0;
        bad_len    = 1'b1;
      end
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_on
    assign lane_on[j] = (CNT_W'(j) < lane_count);
  end

  assign fault = bad_opc | bad_len | (aux_spec != AUX_LEGAL) | (zero_en & dst_mem);

endmodule

// File: rtl/lane_convert.sv
module lane_convert
  import narrow_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  word_in,
  input  narrow_mode_e     mode,
  output logic [OUT_W-1:0] byte_out
);

  logic [IN_W-OUT_W:0] upper_s;
  logic                s_fits;
  logic                u_over;
  logic [OUT_W-1:0]    s_clamp;
  logic [OUT_W-1:0]    u_clamp;

  assign upper_s = word_in[IN_W-1:OUT_W-1];
  assign s_fits  = (~|upper_s) | (&upper_s);
  assign u_over  = |word_in[IN_W-1:OUT_W];

  always_comb begin
    if (s_fits)
      s_clamp = word_in[OUT_W-1:0];
    else if (word_in[IN_W-1])
      s_clamp = {1'b1, {(OUT_W-1){1'b0}}};
    else
      s_clamp = {1'b0, {(OUT_W-1){1'b1}}};
  end

  assign u_clamp = u_over ? {OUT_W{1'b1}} : word_in[OUT_W-1:0];

  always_comb begin
    case (mode)
      NM_SSAT: byte_out = s_clamp;
      NM_USAT: byte_out = u_clamp;
      default: byte_out = word_in[OUT_W-1:0];
    endcase
  end

endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
  parameter int OUT_W = 8
) (
  input  logic [OUT_W-1:0] conv_byte,
  input  logic [OUT_W-1:0] old_byte,
  input  logic             lane_on,
  input  logic             mask_bit,
  input  logic             mask_en,
  input  logic             zero_en,
  input  logic             dst_mem,
  input  logic             fault,
  output logic [OUT_W-1:0] byte_out,
  output logic             we_out
);

  logic take;

  assign take = lane_on & (mask_bit | ~mask_en) & ~fault;

  always_comb begin
    if (fault) begin
      byte_out = '0;
      we_out   = 1'b0;
    end else if (dst_mem) begin
      byte_out = take ? conv_byte : old_byte;
      we_out   = take;
    end else begin
      we_out = 1'b1;
      if (!lane_on)
        byte_out = '0;
      else if (take)
        byte_out = conv_byte;
      else if (zero_en)
        byte_out = '0;
      else
        byte_out = old_byte;
    end
  end

endmodule

// File: rtl/dword_byte_narrower.sv
module dword_byte_narrower
  import narrow_pkg::*;
#(
  parameter int LANES = 16,
  parameter int SRC_W = 32,
  parameter int DST_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [7:0]             opcode,
  input  logic [1:0]             vl_sel,
  input  logic [3:0]             aux_spec,
  input  logic                   mask_en,
  input  logic [LANES-1:0]       mask,
  input  logic                   zero_en,
  input  logic                   dst_mem,
  input  logic [LANES*SRC_W-1:0] src,
  input  logic [LANES*DST_W-1:0] old_dst,
  output logic                   out_valid,
  output logic [LANES*DST_W-1:0] result,
  output logic [LANES-1:0]       byte_we,
  output logic                   ud_fault
);

  localparam int RES_W = LANES * DST_W;

  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  narrow_mode_e     mode;
  logic [LANES-1:0] lane_on;
  logic             fault;

  narrow_decode #(.LANES(LANES)) i_decode (
    .opcode   (opcode),
    .vl_sel   (vl_sel),
    .aux_spec (aux_spec),
    .zero_en  (zero_en),
    .dst_mem  (dst_mem),
    .mode     (mode),
    .lane_on  (lane_on),
    .fault    (fault)
  );

  logic [RES_W-1:0] result_d;
  logic [LANES-1:0] we_d;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [DST_W-1:0] conv;

    lane_convert #(.IN_W(SRC_W), .OUT_W(DST_W)) i_conv (
      .word_in  (src[j*SRC_W +: SRC_W]),
      .mode     (mode),
      .byte_out (conv)
    );

    lane_merge #(.OUT_W(DST_W)) i_merge (
      .conv_byte (conv),
      .old_byte  (old_dst[j*DST_W +: DST_W]),
      .lane_on   (lane_on[j]),
      .mask_bit  (mask[j]),
      .mask_en   (mask_en),
      .zero_en   (zero_en),
      .dst_mem   (dst_mem),
      .fault     (fault),
      .byte_out  (result_d[j*DST_W +: DST_W]),
      .we_out    (we_d[j])
    );
  end

  logic             valid_q, valid_n;
  logic [RES_W-1:0] result_q, result_n;
  logic [LANES-1:0] we_q, we_n;
  logic             fault_q, fault_n;

  always_comb begin
    valid_n  = in_valid;
    result_n = result_q;
    we_n     = we_q;
    fault_n  = fault_q;
    if (in_valid) begin
      result_n = result_d;
      we_n     = we_d;
      fault_n  = fault;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      we_q     <= '0;
      fault_q  <= 1'b0;
    end else begin
      valid_q  <= valid_n;
      result_q <= result_n;
      we_q     <= we_n;
      fault_q  <= fault_n;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign byte_we   = we_q;
  assign ud_fault  = fault_q;

endmodule

// File: rtl/narrow_checker.sv
module narrow_checker #(
  parameter int LANES = 16,
  parameter int DST_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [7:0]             opcode,
  input logic [1:0]             vl_sel,
  input logic [3:0]             aux_spec,
  input logic                   mask_en,
  input logic                   zero_en,
  input logic                   dst_mem,
  input logic [31:0]            src_lo,
  input logic                   out_valid,
  input logic [LANES*DST_W-1:0] result,
  input logic [LANES-1:0]       byte_we,
  input logic                   ud_fault
);

  localparam int Q = LANES / 4;
  localparam int H = LANES / 2;

  assert_valid_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(result) && $stable(byte_we) && $stable(ud_fault)));

  assert_aux_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(aux_spec) != 4'b1111) |->
      (ud_fault && byte_we == '0 && result == '0));

  assert_zero_mem_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && zero_en && dst_mem) |-> (ud_fault && byte_we == '0));

  assert_mem_enable_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && dst_mem && vl_sel == 2'd0) && !ud_fault) |->
      (byte_we[LANES-1:Q] == '0));

  assert_reg_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && !dst_mem && vl_sel == 2'd1) && !ud_fault) |->
      (result[LANES*DST_W-1:H*DST_W] == '0 && byte_we == '1));

  assert_usat_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && opcode == 8'h11 && !mask_en && !dst_mem &&
          aux_spec == 4'b1111 && vl_sel != 2'd3 && src_lo[31:8] != 24'd0) |->
      (result[7:0] == 8'hFF));

endmodule

bind dword_byte_narrower narrow_checker #(.LANES(LANES), .DST_W(DST_W)) i_narrow_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .vl_sel    (vl_sel),
  .aux_spec  (aux_spec),
  .mask_en   (mask_en),
  .zero_en   (zero_en),
  .dst_mem   (dst_mem),
  .src_lo    (src[31:0]),
  .out_valid (out_valid),
  .result    (result),
  .byte_we   (byte_we),
  .ud_fault  (ud_fault)
);

// File: tb/test_dword_byte_narrower.sv
module test_dword_byte_narrower;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [7:0]   opcode;
  logic [1:0]   vl_sel;
  logic [3:0]   aux_spec;
  logic         mask_en;
  logic [15:0]  mask;
  logic         zero_en;
  logic         dst_mem;
  logic [511:0] src;
  logic [127:0] old_dst;
  logic         out_valid;
  logic [127:0] result;
  logic [15:0]  byte_we;
  logic         ud_fault;

  dword_byte_narrower i_dword_byte_narrower (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .vl_sel(vl_sel), .aux_spec(aux_spec), .mask_en(mask_en), .mask(mask),
    .zero_en(zero_en), .dst_mem(dst_mem), .src(src), .old_dst(old_dst),
    .out_valid(out_valid), .result(result), .byte_we(byte_we), .ud_fault(ud_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct packed {
    logic [7:0]  op;
    logic [1:0]  vl;
    logic [15:0] msk;
    logic        me;
    logic        ze;
    logic        mem;
    logic [3:0]  aux;
    logic [7:0]  seed;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{8'h31, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 4'hF, 8'd0,  4'd1},  // R1 truncation, 16 lanes
    '{8'h31, 2'd0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 4'hF, 8'd5,  4'd1},  // R1 truncation, 4 lanes
    '{8'h11, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 4'hF, 8'd1,  4'd2},  // R2 unsigned clamp
    '{8'h11, 2'd1, 16'h00FF, 1'b1, 1'b0, 1'b0, 4'hF, 8'd7,  4'd2},  // R2 unsigned clamp, 8 lanes
    '{8'h21, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 4'hF, 8'd2,  4'd3},  // R3 signed clamp
    '{8'h21, 2'd2, 16'hFFFF, 1'b1, 1'b0, 1'b0, 4'hF, 8'd9,  4'd3},  // R3 signed clamp, other rotation
    '{8'h11, 2'd2, 16'hA5C3, 1'b1, 1'b0, 1'b0, 4'hF, 8'd3,  4'd4},  // R4 merging
    '{8'h21, 2'd1, 16'h0F0F, 1'b1, 1'b0, 1'b0, 4'hF, 8'd4,  4'd4},  // R4 merging, 8 lanes
    '{8'h31, 2'd2, 16'h3C96, 1'b1, 1'b1, 1'b0, 4'hF, 8'd6,  4'd5},  // R5 zeroing
    '{8'h11, 2'd0, 16'h0005, 1'b1, 1'b1, 1'b0, 4'hF, 8'd8,  4'd5},  // R5 zeroing, 4 lanes
    '{8'h21, 2'd2, 16'h0000, 1'b1, 1'b0, 1'b0, 4'hF, 8'd10, 4'd4},  // R4 empty mask keeps all old
    '{8'h11, 2'd2, 16'h1234, 1'b0, 1'b1, 1'b0, 4'hF, 8'd11, 4'd6},  // R6 mask and zeroing ignored
    '{8'h31, 2'd1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 4'hF, 8'd12, 4'd7},  // R7 upper bytes cleared
    '{8'h11, 2'd2, 16'hBEEF, 1'b1, 1'b0, 1'b1, 4'hF, 8'd13, 4'd8},  // R8 memory store, sparse mask
    '{8'h21, 2'd0, 16'hFFFF, 1'b0, 1'b0, 1'b1, 4'hF, 8'd14, 4'd8},  // R8 memory store, 4 lanes
    '{8'h31, 2'd1, 16'hF00F, 1'b1, 1'b0, 1'b1, 4'hF, 8'd15, 4'd8},  // R8 memory store, 8 lanes
    '{8'h31, 2'd2, 16'hFFFF, 1'b0, 1'b0, 1'b0, 4'hE, 8'd1,  4'd9},  // R9 bad specifier
    '{8'h11, 2'd1, 16'hFFFF, 1'b0, 1'b0, 1'b1, 4'h7, 8'd2,  4'd9},  // R9 bad specifier, memory
    '{8'h11, 2'd2, 16'hFFFF, 1'b1, 1'b1, 1'b1, 4'hF, 8'd3,  4'd10}, // R10 zeroing to memory
    '{8'h51, 2'd2, 16'hFFFF, 1'b0, 1'b0, 1'b0, 4'hF, 8'd4,  4'd11}, // R11 unknown opcode
    '{8'h31, 2'd3, 16'hFFFF, 1'b0, 1'b0, 1'b0, 4'hF, 8'd5,  4'd11}, // R11 reserved length
    '{8'h21, 2'd2, 16'h0F0F, 1'b0, 1'b1, 1'b1, 4'h0, 8'd6,  4'd10}  // R10 with bad specifier too
  };

  function automatic logic [31:0] corner(input int k);
    case (k % 12)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0001;
      2:  return 32'h0000_007F;
      3:  return 32'h0000_0080;
      4:  return 32'h0000_00FF;
      5:  return 32'h0000_0100;
      6:  return 32'h7FFF_FFFF;
      7:  return 32'h8000_0000;
      8:  return 32'hFFFF_FFFF;
      9:  return 32'hFFFF_FF80;
      10: return 32'hFFFF_FF7F;
      default: return 32'h1234_5678;
    endcase
  endfunction

  function automatic logic [511:0] make_src(input logic [7:0] seed);
    logic [511:0] v;
    for (int j = 0; j < 16; j++) v[j*32 +: 32] = corner(int'(seed) + 5 * j);
    return v;
  endfunction

  function automatic logic [127:0] make_old(input logic [7:0] seed);
    logic [127:0] v;
    for (int j = 0; j < 16; j++) v[j*8 +: 8] = seed ^ 8'hA5 ^ 8'(j * 17);
    return v;
  endfunction

  function automatic logic [7:0] model_byte(input logic [7:0] op, input logic [31:0] w);
    int signed sv;
    sv = $signed(w);
    if (op == 8'h11) return (w > 32'd255) ? 8'hFF : w[7:0];
    if (op == 8'h21) begin
      if (sv > 127)  return 8'h7F;
      if (sv < -128) return 8'h80;
      return w[7:0];
    end
    return w[7:0];
  endfunction

  task automatic model(input vec_t v, output logic [127:0] er, output logic [15:0] ew,
                       output logic ef);
    logic [511:0] s;
    logic [127:0] o;
    int kl;
    s  = make_src(v.seed);
    o  = make_old(v.seed);
    ef = (v.aux != 4'hF) || (v.vl == 2'd3) || (v.ze && v.mem) ||
         !(v.op == 8'h31 || v.op == 8'h21 || v.op == 8'h11);
    er = '0;
    ew = '0;
    kl = 4 << v.vl;
    if (!ef) begin
      for (int j = 0; j < 16; j++) begin
        logic wr;
        wr = (j < kl) && (v.msk[j] || !v.me);
        if (v.mem) begin
          ew[j] = wr;
          er[j*8 +: 8] = wr ? model_byte(v.op, s[j*32 +: 32]) : o[j*8 +: 8];
        end else begin
          ew[j] = 1'b1;
          if (j >= kl)    er[j*8 +: 8] = 8'h00;
          else if (wr)    er[j*8 +: 8] = model_byte(v.op, s[j*32 +: 32]);
          else if (v.ze)  er[j*8 +: 8] = 8'h00;
          else            er[j*8 +: 8] = o[j*8 +: 8];
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [127:0] er, input logic [15:0] ew,
                       input logic ef, input logic ev);
    n_checks++;
    if (result !== er || byte_we !== ew || ud_fault !== ef || out_valid !== ev) begin
      n_fails++;
      $display("FAIL %s: got res=%h we=%h flt=%b vld=%b expected res=%h we=%h flt=%b vld=%b",
               tag, result, byte_we, ud_fault, out_valid, er, ew, ef, ev);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    opcode   = v.op;
    vl_sel   = v.vl;
    mask     = v.msk;
    mask_en  = v.me;
    zero_en  = v.ze;
    dst_mem  = v.mem;
    aux_spec = v.aux;
    src      = make_src(v.seed);
    old_dst  = make_old(v.seed);
    in_valid = vld;
  endtask

  initial begin
    #(20 * 150000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [127:0] er;
    logic [15:0]  ew;
    logic         ef;
    vec_t         last;

    rst_n = 1'b0;
    drive(VECS[0], 1'b0);
    repeat (3) @(negedge clk);
    check("R12 reset state", '0, '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 idle after reset", '0, '0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      model(VECS[i], er, ew, ef);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), er, ew, ef, 1'b1);
    end

    // R12: with in_valid low, new operands must not reach the outputs
    last = VECS[NV-1];
    model(VECS[6], er, ew, ef);
    drive(VECS[6], 1'b1);
    @(negedge clk);
    drive(VECS[2], 1'b0);
    @(negedge clk);
    check("R12 hold while idle", er, ew, ef, 1'b0);
    drive(last, 1'b0);
    @(negedge clk);
    check("R12 hold second idle cycle", er, ew, ef, 1'b0);

    // R12: back-to-back operations update on consecutive edges
    drive(VECS[13], 1'b1);
    @(negedge clk);
    model(VECS[13], er, ew, ef);
    check("R12 back-to-back first", er, ew, ef, 1'b1);
    drive(VECS[9], 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    model(VECS[9], er, ew, ef);
    check("R12 back-to-back second", er, ew, ef, 1'b1);

    // R12: asynchronous reset clears the registered result
    #3 rst_n = 1'b0;
    #2;
    check("R12 async reset clears", '0, '0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 idle after second reset", '0, '0, 1'b0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule